// File: doc/BRIEF.md
# Receive Descriptor Ring Filler

This block takes one received frame at a time from a byte stream and spreads it over a circular ring of 8-byte receive descriptors held in system memory. It first collects the whole frame in an internal store. Then it walks the ring through a 32-bit memory master port. For each descriptor it reads the flag/length word and the buffer pointer. It writes bytes into the buffer one at a time, then writes the updated flag/length word back. The byte stream written for a frame has three parts, in this order: an optional zeroed control block, the frame data, and trailing zero bytes that stand in for the CRC and the minimum-length fill.

When the walker runs out of empty descriptors, or comes back round to the descriptor where it started, it halts the ring. It keeps the resume position and the unwritten remainder of the frame. A restart pulse continues the same frame from that point. No new frame is accepted while one is pending.

Top module: `rx_ring_filler`

## Requirements
- R1: `in_ready` is high exactly when no frame is pending (`busy` low), `rx_enable` is high and `rx_stop` is low. A halted ring always counts as pending.
- R2: With `drop_short` set, a frame of fewer than 60 bytes is discarded once its last byte arrives. Memory is not touched, no event fires, and `busy` stays low.
- R3: After the frame data the block writes zero bytes: 4 for the CRC, plus 60 minus the frame length when the frame is shorter than 60 bytes.
- R4: With `parse_en` set, 8 + `fcb_align` zero bytes are written at the start of the frame's first buffer, ahead of the data. They count toward that descriptor's length.
- R5: Only descriptors whose empty flag (bit 15) is set are filled. Each takes at most `buf_max` bytes. On write-back its empty flag is cleared and its length field holds the number of bytes written to it.
- R6: The first descriptor filled for a frame gets the first flag (bit 10). The descriptor that takes the final byte gets the last flag (bit 11).
- R7: On the last descriptor, the length-violation flag (bit 5) is set when frame length plus padding is at least `frame_max`. The control block is not counted.
- R8: On the last descriptor, when its interrupt flag (bit 12) is set, `ev_frame` pulses once and `frame_stat` becomes and stays high. On any other filled descriptor with bit 12 set, `ev_buffer` pulses once.
- R9: After a descriptor is written back, the walker moves to the ring base if the wrap flag (bit 13) was set, and otherwise to the next 8-byte slot. It stops at a non-empty descriptor and leaves the pointer on that descriptor. It also stops when it comes back to the descriptor it started from.
- R10: If frame bytes remain when the walker stops, `halted` goes high and stays high until a `ring_restart` pulse. The pulse resumes the same frame at the saved descriptor, with the remaining bytes.
- R11: Descriptor layout: flags at offset 0, length at offset 2, buffer pointer at offset 4. With `little_endian` low each field is stored most significant byte first; with it high, least significant byte first. The byte at address a travels on `mem_wdata`/`mem_rdata` bits [8*(a mod 4)+7 : 8*(a mod 4)]. Read data is valid the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receive enable |
| rx_stop | input | 1 | Graceful receive stop: refuse new frames |
| drop_short | input | 1 | Discard frames under 60 bytes |
| parse_en | input | 1 | Prepend zeroed control block |
| fcb_align | input | 5 | Extra control-block bytes beyond 8 |
| little_endian | input | 1 | Descriptor byte order select |
| buf_max | input | 16 | Maximum bytes per receive buffer |
| frame_max | input | 16 | Length-violation threshold |
| ring_restart | input | 1 | Pulse: clear halt and resume |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks final byte of frame |
| in_ready | output | 1 | Block accepts input byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | ADDR_W | Byte address |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after request |
| busy | output | 1 | A frame is pending |
| halted | output | 1 | Ring halted with data remaining |
| ev_frame | output | 1 | Frame-received event pulse |
| ev_buffer | output | 1 | Buffer-received event pulse |
| frame_stat | output | 1 | Sticky frame-completed status |

## Verification
The bench keeps the defaults `ADDR_W=16` and `BUF_BYTES=256`, with `RING_BASE=0x100` and a six-descriptor ring whose last entry wraps. The store is deep enough for a 200-byte frame. With a 32-byte buffer limit that frame overruns the ring's 192 bytes of capacity, so the return-to-start halt and its resume can be reached. Small frames fill two or three descriptors, so every frame scatters over several buffers. Frames of 20 and 70 bytes exercise the minimum-length fill, the control block in the first buffer, and a length-violation threshold set exactly at frame length plus padding.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int FL_EMPTY = 15;
  localparam int FL_WRAP  = 13;
  localparam int FL_INTR  = 12;
  localparam int FL_LAST  = 11;
  localparam int FL_FIRST = 10;
  localparam int FL_LENV  = 5;

  localparam int CRC_BYTES = 4;
  localparam int MIN_BODY  = 60;
  localparam int FCB_BASE  = 8;
  localparam int DESC_SIZE = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_RECV, S_RD0, S_RD0W, S_RD1, S_RD1W, S_FILL, S_WB, S_HALT
  } walk_st_e;

  function automatic logic [15:0] pad_bytes(input logic [15:0] len);
    return 16'(CRC_BYTES) + ((len < 16'(MIN_BODY)) ? (16'(MIN_BODY) - len) : 16'd0);
  endfunction

  function automatic logic [15:0] fcb_bytes(input logic en, input logic [4:0] align);
    return en ? (16'(FCB_BASE) + {11'd0, align}) : 16'd0;
  endfunction

  function automatic logic [31:0] bswap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/rxr_frame_buf.sv
module rxr_frame_buf #(
  parameter int DEPTH = 256,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte,
  output logic [CNT_W-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0] store [DEPTH];
  logic       room;

  assign room = (count < CNT_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (clr)            count <= '0;
    else if (wr_en && room)  count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr && room) store[count[AW-1:0]] <= wr_byte;
  end

  assign rd_byte = (rd_idx < IDX_W'(DEPTH)) ? store[rd_idx[AW-1:0]] : 8'h00;
endmodule

// File: rtl/rxr_desc_codec.sv
module rxr_desc_codec
  import rxr_pkg::*;
(
  input  logic        le,
  input  logic [31:0] rd_word,
  output logic [15:0] rd_flags,
  output logic [15:0] rd_len,
  output logic [31:0] rd_ptr,
  input  logic [15:0] wr_flags,
  input  logic [15:0] wr_len,
  output logic [31:0] wr_word
);
  logic [31:0] logical;

  assign logical  = le ? {rd_word[15:0], rd_word[31:16]} : bswap32(rd_word);
  assign rd_flags = logical[31:16];
  assign rd_len   = logical[15:0];
  assign rd_ptr   = le ? rd_word : bswap32(rd_word);
  assign wr_word  = le ? {wr_len, wr_flags} : bswap32({wr_flags, wr_len});
endmodule

// File: rtl/rxr_byte_lane.sv
module rxr_byte_lane #(
  parameter int LANES = 4,
  parameter int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0]   offs,
  input  logic [7:0]         data,
  output logic [8*LANES-1:0] wdata,
  output logic [LANES-1:0]   be
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wdata[8*g +: 8] = data;
    assign be[g]           = (offs == OFF_W'(g));
  end
endmodule

// File: rtl/rx_ring_filler.sv
module rx_ring_filler
  import rxr_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                BUF_BYTES = 256,
  parameter logic [ADDR_W-1:0] RING_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic              rx_stop,
  input  logic              drop_short,
  input  logic              parse_en,
  input  logic [4:0]        fcb_align,
  input  logic              little_endian,
  input  logic [15:0]       buf_max,
  input  logic [15:0]       frame_max,
  input  logic              ring_restart,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              halted,
  output logic              ev_frame,
  output logic              ev_buffer,
  output logic              frame_stat
);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);
  localparam int LEN_W = 16;

  walk_st_e          st;
  logic [ADDR_W-1:0] desc_ptr, start_ptr, d_buf, next_ptr, byte_addr;
  logic [15:0]       d_flags;
  logic [LEN_W-1:0]  frame_len, frame_total, data_idx, pad_left, fcb_left, wr_cnt;
  logic              first_pend, halted_q, stat_q;

  // events between pieces of logic, visible to the checker
  logic              take, stream_left, byte_wr, last_now, fb_clr;
  logic [7:0]        fill_byte, fb_rd;
  logic [CNT_W-1:0]  fb_count;
  logic [LEN_W-1:0]  new_len, cnt16;
  logic [15:0]       rd_flags, rd_len, wb_flags;
  logic [31:0]       rd_ptr, wb_word, lane_wdata;
  logic [3:0]        lane_be;

  assign busy     = (st != S_IDLE) && (st != S_RECV);
  assign in_ready = !busy && rx_enable && !rx_stop;
  assign take     = in_valid && in_ready;
  assign halted   = halted_q;
  assign frame_stat = stat_q;

  assign cnt16   = LEN_W'(fb_count);
  assign new_len = (fb_count < CNT_W'(BUF_BYTES)) ? cnt16 + 1'b1 : cnt16;

  assign stream_left = (fcb_left != '0) || (data_idx < frame_len) || (pad_left != '0);
  assign byte_wr     = (st == S_FILL) && stream_left && (wr_cnt < buf_max);
  assign last_now    = !stream_left;
  assign fill_byte   = (fcb_left != '0) ? 8'h00 : ((data_idx < frame_len) ? fb_rd : 8'h00);
  assign byte_addr   = d_buf + ADDR_W'(wr_cnt);
  assign next_ptr    = d_flags[FL_WRAP] ? RING_BASE : desc_ptr + ADDR_W'(DESC_SIZE);

  assign fb_clr = (take && in_last && drop_short && new_len < 16'(MIN_BODY))
               || (st == S_WB && last_now);

  always_comb begin
    wb_flags = d_flags;
    wb_flags[FL_EMPTY] = 1'b0;
    if (first_pend) wb_flags[FL_FIRST] = 1'b1;
    if (last_now) begin
      wb_flags[FL_LAST] = 1'b1;
      if (frame_total >= frame_max) wb_flags[FL_LENV] = 1'b1;
    end
  end

  assign ev_frame  = (st == S_WB) && last_now && d_flags[FL_INTR];
  assign ev_buffer = (st == S_WB) && !last_now && d_flags[FL_INTR];

  rxr_frame_buf #(.DEPTH(BUF_BYTES), .CNT_W(CNT_W), .IDX_W(LEN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(fb_clr), .wr_en(take), .wr_byte(in_data),
    .rd_idx(data_idx), .rd_byte(fb_rd), .count(fb_count)
  );

  rxr_desc_codec u_codec (
    .le(little_endian), .rd_word(mem_rdata), .rd_flags(rd_flags), .rd_len(rd_len),
    .rd_ptr(rd_ptr), .wr_flags(wb_flags), .wr_len(wr_cnt), .wr_word(wb_word)
  );

  rxr_byte_lane #(.LANES(4)) u_lane (
    .offs(byte_addr[1:0]), .data(fill_byte), .wdata(lane_wdata), .be(lane_be)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_ptr;
    mem_be    = 4'h0;
    mem_wdata = 32'h0;
    unique case (st)
      S_RD0: mem_req = 1'b1;
      S_RD1: begin
        mem_req  = 1'b1;
        mem_addr = desc_ptr + ADDR_W'(4);
      end
      S_FILL: if (byte_wr) begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = byte_addr;
        mem_be    = lane_be;
        mem_wdata = lane_wdata;
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_be    = 4'hF;
        mem_wdata = wb_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      desc_ptr    <= RING_BASE;
      start_ptr   <= RING_BASE;
      d_buf       <= '0;
      d_flags     <= '0;
      frame_len   <= '0;
      frame_total <= '0;
      data_idx    <= '0;
      pad_left    <= '0;
      fcb_left    <= '0;
      wr_cnt      <= '0;
      first_pend  <= 1'b0;
      halted_q    <= 1'b0;
      stat_q      <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE, S_RECV: if (take) begin
          if (!in_last) st <= S_RECV;
          else if (drop_short && new_len < 16'(MIN_BODY)) st <= S_IDLE;
          else begin
            frame_len   <= new_len;
            frame_total <= new_len + pad_bytes(new_len);
            pad_left    <= pad_bytes(new_len);
            fcb_left    <= fcb_bytes(parse_en, fcb_align);
            data_idx    <= '0;
            first_pend  <= 1'b1;
            start_ptr   <= desc_ptr;
            st          <= S_RD0;
          end
        end
        S_RD0: st <= S_RD0W;
        S_RD0W: begin
          if (!rd_flags[FL_EMPTY]) begin
            halted_q <= 1'b1;
            st       <= S_HALT;
          end else begin
            d_flags <= rd_flags;
            st      <= S_RD1;
          end
        end
        S_RD1: st <= S_RD1W;
        S_RD1W: begin
          d_buf  <= rd_ptr[ADDR_W-1:0];
          wr_cnt <= '0;
          st     <= S_FILL;
        end
        S_FILL: begin
          if (byte_wr) begin
            wr_cnt <= wr_cnt + 1'b1;
            if (fcb_left != '0)            fcb_left <= fcb_left - 1'b1;
            else if (data_idx < frame_len) data_idx <= data_idx + 1'b1;
            else                           pad_left <= pad_left - 1'b1;
          end else begin
            st <= S_WB;
          end
        end
        S_WB: begin
          first_pend <= 1'b0;
          desc_ptr   <= next_ptr;
          if (last_now && d_flags[FL_INTR]) stat_q <= 1'b1;
          if (last_now) st <= S_IDLE;
          else if (next_ptr == start_ptr) begin
            halted_q <= 1'b1;
            st       <= S_HALT;
          end else st <= S_RD0;
        end
        S_HALT: if (ring_restart) begin
          halted_q  <= 1'b0;
          start_ptr <= desc_ptr;
          st        <= S_RD0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxr_fill_checker.sv
module rxr_fill_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              busy,
  input logic              halted,
  input logic              ring_restart,
  input logic              ev_frame,
  input logic              ev_buffer,
  input logic              frame_stat,
  input logic              mem_req,
  input logic              mem_we,
  input logic [3:0]        mem_be,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              byte_wr,
  input logic [15:0]       fill_cnt,
  input logic [15:0]       buf_max
);
  p_ready_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  p_halt_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> busy);

  p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !ring_restart) |=> halted);

  p_event_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_frame && ev_buffer));

  p_stat_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stat |=> frame_stat);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr |-> (fill_cnt < buf_max));

  p_lane_select_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be == 4'hF || $countones(mem_be) == 1));

  p_word_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be == 4'hF) |-> (mem_addr[1:0] == 2'b00));
endmodule

bind rx_ring_filler rxr_fill_checker #(.ADDR_W(ADDR_W)) u_fill_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .busy(busy), .halted(halted),
  .ring_restart(ring_restart), .ev_frame(ev_frame), .ev_buffer(ev_buffer),
  .frame_stat(frame_stat), .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
  .mem_addr(mem_addr), .byte_wr(byte_wr), .fill_cnt(wr_cnt), .buf_max(buf_max)
);

// File: tb/rx_ring_filler_test.sv
module rx_ring_filler_test;
  localparam int ADDR_W = 16;
  localparam logic [15:0] RBASE = 16'h0100;
  localparam int NDESC = 6;
  localparam int MEMB = 4096;

  logic clk = 0, rst_n = 0;
  logic rx_enable = 1, rx_stop = 0, drop_short = 0, parse_en = 0, little_endian = 0;
  logic [4:0] fcb_align = 0;
  logic [15:0] buf_max = 16'd32, frame_max = 16'd1518;
  logic ring_restart = 0, in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic in_ready, mem_req, mem_we, busy, halted, ev_frame, ev_buffer, frame_stat;
  logic [ADDR_W-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  rx_ring_filler #(.ADDR_W(ADDR_W), .BUF_BYTES(256), .RING_BASE(RBASE)) uut (.*);

  logic [7:0] mem  [MEMB];
  logic [7:0] emem [MEMB];
  int checks = 0, fails = 0, cyc = 0;
  int got_frames = 0, got_bufs = 0, exp_frames = 0, exp_bufs = 0;
  bit exp_stat = 0;

  // memory model: byte lanes, read data one cycle after the request
  always @(posedge clk) begin
    if (mem_req && !mem_we)
      mem_rdata <= {mem[{mem_addr[11:2],2'b11}], mem[{mem_addr[11:2],2'b10}],
                    mem[{mem_addr[11:2],2'b01}], mem[{mem_addr[11:2],2'b00}]};
    if (mem_req && mem_we)
      for (int l = 0; l < 4; l++)
        if (mem_be[l]) mem[{mem_addr[11:2], 2'(l)}] <= mem_wdata[8*l +: 8];
    if (rst_n && ev_frame)  got_frames++;
    if (rst_n && ev_buffer) got_bufs++;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-clock comparison of the input handshake against R1
  always @(negedge clk) if (rst_n) begin
    checks++;
    if (in_ready !== (!busy && rx_enable && !rx_stop)) begin
      fails++;
      $display("FAIL R1: in_ready actual %0b expected %0b", in_ready, !busy && rx_enable && !rx_stop);
    end
    if (halted && !busy) begin
      fails++;
      $display("FAIL R10: halted without pending frame, actual busy 0 expected 1");
    end
  end

  // ---- reference model ----
  logic [7:0] q [$];
  int m_ptr = RBASE, m_start, fcb_l, pad_l, m_size;
  bit m_first, m_halt;

  function automatic int rd16(input int a);
    return little_endian ? {emem[a+1], emem[a]} : {emem[a], emem[a+1]};
  endfunction
  function automatic int rd32(input int a);
    return little_endian ? {emem[a+3], emem[a+2], emem[a+1], emem[a]}
                         : {emem[a], emem[a+1], emem[a+2], emem[a+3]};
  endfunction
  task automatic put_desc(input int a, input int fl, input int ln, input int bp, input bit both);
    logic [7:0] b [8];
    if (little_endian) begin
      b[0]=fl[7:0]; b[1]=fl[15:8]; b[2]=ln[7:0]; b[3]=ln[15:8];
      b[4]=bp[7:0]; b[5]=bp[15:8]; b[6]=bp[23:16]; b[7]=bp[31:24];
    end else begin
      b[0]=fl[15:8]; b[1]=fl[7:0]; b[2]=ln[15:8]; b[3]=ln[7:0];
      b[4]=bp[31:24]; b[5]=bp[23:16]; b[6]=bp[15:8]; b[7]=bp[7:0];
    end
    for (int k = 0; k < (both ? 8 : 4); k++) begin
      emem[a+k] = b[k];
      if (both) mem[a+k] = b[k];
    end
  endtask

  task automatic arm_ring();
    for (int i = 0; i < NDESC; i++)
      put_desc(RBASE + 8*i, 16'h9000 | ((i == NDESC-1) ? 16'h2000 : 16'h0), 0, 16'h0200 + 64*i, 1);
  endtask

  task automatic model_walk();
    m_start = m_ptr;
    m_halt  = 0;
    forever begin
      int fl, bp, n, nf;
      bit last;
      fl = rd16(m_ptr);
      if (!fl[15]) begin m_halt = 1; break; end
      bp = rd32(m_ptr + 4);
      n = 0;
      while (n < int'(buf_max) && (fcb_l > 0 || q.size() > 0 || pad_l > 0)) begin
        logic [7:0] b = 0;
        if (fcb_l > 0) fcb_l--;
        else if (q.size() > 0) b = q.pop_front();
        else pad_l--;
        emem[bp + n] = b;
        n++;
      end
      last = (fcb_l == 0 && q.size() == 0 && pad_l == 0);
      nf = fl & 16'h7FFF;
      if (m_first) nf |= 16'h0400;
      m_first = 0;
      if (last) begin
        nf |= 16'h0800;
        if (m_size >= int'(frame_max)) nf |= 16'h0020;
      end
      if (fl[12]) begin
        if (last) begin exp_frames++; exp_stat = 1; end
        else exp_bufs++;
      end
      put_desc(m_ptr, nf, n, bp, 0);
      m_ptr = fl[13] ? RBASE : m_ptr + 8;
      if (last) break;
      if (m_ptr == m_start) begin m_halt = 1; break; end
    end
  endtask

  task automatic start_model(input int n);
    pad_l   = 4 + ((n < 60) ? 60 - n : 0);
    fcb_l   = parse_en ? 8 + fcb_align : 0;
    m_size  = n + pad_l;
    m_first = 1;
    model_walk();
  endtask

  task automatic send_frame(input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b = 8'((k * 7 + seed) & 255);
      in_valid = 1; in_data = b; in_last = (k == n - 1);
      q.push_back(b);
      @(posedge clk); @(negedge clk);
    end
    in_valid = 0; in_last = 0;
  endtask

  task automatic wait_walk();
    @(negedge clk);
    while (busy && !halted) @(negedge clk);
  endtask

  task automatic compare_mem(input string req);
    int bad = -1;
    for (int a = 0; a < MEMB; a++)
      if (mem[a] !== emem[a] && bad < 0) bad = a;
    check(bad < 0, req, (bad < 0) ? 0 : int'(mem[bad]), (bad < 0) ? 0 : int'(emem[bad]));
    if (bad >= 0) $display("  first mismatch at byte address 0x%0h", bad);
  endtask

  task automatic check_events(input string req);
    check(got_frames == exp_frames, {req, " frame events"}, got_frames, exp_frames);
    check(got_bufs == exp_bufs, {req, " buffer events"}, got_bufs, exp_bufs);
    check(frame_stat == exp_stat, {req, " frame_stat"}, frame_stat, exp_stat);
  endtask

  task automatic restart();
    ring_restart = 1; @(negedge clk); ring_restart = 0;
  endtask

  initial begin
    for (int a = 0; a < MEMB; a++) begin mem[a] = 0; emem[a] = 0; end
    repeat (3) @(negedge clk);
    // reset state
    check(in_ready == 1, "R1 reset in_ready", in_ready, 1);
    check(busy == 0, "R1 reset busy", busy, 0);
    check(halted == 0, "R10 reset halted", halted, 0);
    check(mem_req == 0, "R11 reset mem_req", mem_req, 0);
    rst_n = 1;
    @(negedge clk);

    // big-endian, 100-byte frame over four buffers: R5 R6 R8 R9 R11
    arm_ring();
    send_frame(100, 3); start_model(100); wait_walk();
    compare_mem("R5 R6 R9 R11 big-endian scatter");
    check_events("R8");
    check(busy == 0, "R6 done", busy, 0);

    // little-endian with control block, short frame padded: R3 R4 R11
    little_endian = 1; parse_en = 1; fcb_align = 5'd3;
    arm_ring();
    send_frame(20, 41); start_model(20); wait_walk();
    compare_mem("R3 R4 R11 control block and padding");
    check_events("R8");
    parse_en = 0;

    // short frame discarded: R2
    drop_short = 1;
    arm_ring();
    send_frame(20, 9); q.delete(); @(negedge clk);
    check(busy == 0, "R2 busy after drop", busy, 0);
    compare_mem("R2 memory untouched");
    check_events("R2");
    drop_short = 0;

    // refusal inputs: R1
    rx_stop = 1; #1;
    check(in_ready == 0, "R1 graceful stop", in_ready, 0);
    rx_stop = 0; rx_enable = 0; #1;
    check(in_ready == 0, "R1 receive disabled", in_ready, 0);
    rx_enable = 1; @(negedge clk);

    // length violation at threshold: R7
    frame_max = 16'd74; little_endian = 0;
    arm_ring();
    send_frame(70, 17); start_model(70); wait_walk();
    compare_mem("R7 length violation");
    frame_max = 16'd1518;

    // non-empty descriptor halts, resume: R9 R10
    arm_ring();
    put_desc(RBASE + 8 * ((((m_ptr - RBASE) / 8) + 2) % NDESC), 16'h1000, 0, 16'h0200, 1);
    send_frame(100, 77); start_model(100); wait_walk();
    check(halted == 1, "R10 halt on non-empty", halted, 1);
    check(in_ready == 0, "R1 refused while halted", in_ready, 0);
    compare_mem("R9 stop at non-empty");
    repeat (5) @(negedge clk);
    check(halted == 1, "R10 halt held", halted, 1);
    arm_ring(); restart(); model_walk(); wait_walk();
    check(halted == 0, "R10 resumed", halted, 0);
    compare_mem("R10 remainder after resume");
    check_events("R8");

    // frame larger than ring: back at start, resume: R9 R10
    arm_ring();
    send_frame(200, 5); start_model(200); wait_walk();
    check(halted == 1, "R9 halt at start descriptor", halted, 1);
    compare_mem("R9 full lap");
    arm_ring(); restart(); model_walk(); wait_walk();
    check(busy == 0, "R10 lap resume done", busy, 0);
    compare_mem("R10 lap remainder");
    check_events("R8");

    summary();
  end
endmodule